// File: doc/BRIEF.md
# Processor Slot Hotplug Event Controller

This block records hot-add and hot-remove events for a fixed set of processor slots and presents them to firmware through a small register window. Platform logic pulses a per-slot hot-add or hot-remove input. The block keeps an enabled, an insert-pending and a remove-pending flag for every slot, and it holds a level interrupt high while any event is still pending.

Firmware works on one slot at a time. It picks that slot through a selector register, then reads the slot's flags or writes a control byte to acknowledge events or to eject the slot. A command byte can ask the block to move the selector to the lowest-numbered slot that has an event pending. The same command byte sets the meaning of a dword data register, which can also capture two status words and emit them on a one-cycle notification pulse.

After reset the block starts in a compatibility mode. In that mode the window shows only a read-only bitmap of enabled slots. A single all-zero dword write switches it to the selector-based interface, and the block stays there until reset.

Top module: `slot_hp_ctrl`

## Requirements
- R1: After reset the block is in compatibility mode, every slot flag is clear, the selector is 0, the command is 0, and rdata, irq, eject_stb, ost_vld, ost_evt and ost_sts are all 0.
- R2: A pulse on hp_add[i] sets slot i's enabled and insert flags. A pulse on hp_rem[i] sets its remove flag. irq is high exactly while at least one insert or remove flag is set.
- R3: In compatibility mode, a read of dword 0 (addr[3:2]=0) returns the enabled bitmap, with bit i standing for slot i, and every other dword reads 0. Every write is ignored except one with addr[3:2]=0, be=4'hF and wdata=0. That write switches the block to selector mode permanently.
- R4: Read data appears on rdata in the cycle after rd and is 0 when no read was issued. In selector mode, dword 1 reads bit 0 = enabled, bit 1 = insert and bit 2 = remove of the selected slot, with all other bits 0. Dword 0 reads 0.
- R5: A selector-mode write to dword 1 with be[0] set acts as the control byte. Bit 1 clears the selected slot's insert flag and bit 2 clears its remove flag. Bits 0 and 4-7 have no effect. A hot-add or hot-remove pulse in the same cycle takes precedence over the clear.
- R6: Control bit 3 ejects the selected slot. This clears its enabled and remove flags and raises eject_stb for one cycle, with eject_slot equal to the slot index, in the cycle after the write.
- R7: While the selector is NUM_SLOTS or more, a status read returns 0 and control writes change no flag and raise no eject_stb.
- R8: A write to dword 1 with be[1] set loads the command from wdata[15:8]. Command 0 moves the selector to the lowest-indexed slot with a pending insert or remove flag, or leaves the selector unchanged if there is none. While the command is 0, a read of dword 2 returns the selector.
- R9: With command 1, a write to dword 2 loads ost_evt through the byte enables. With command 2, it loads ost_sts the same way and raises ost_vld for one cycle in the next cycle, together with the updated ost_evt and ost_sts.
- R10: A selector-mode read of dword 2 returns 32'hFFFFFFFF whenever the command is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte address in the window; addr[3:2] selects the dword |
| be | input | 4 | Byte-lane enables for writes |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd |
| hp_add | input | NUM_SLOTS | Per-slot hot-add pulse |
| hp_rem | input | NUM_SLOTS | Per-slot hot-remove request pulse |
| irq | output | 1 | Level interrupt while any event is pending |
| eject_stb | output | 1 | One-cycle eject strobe |
| eject_slot | output | $clog2(NUM_SLOTS) | Index of the slot being ejected |
| ost_vld | output | 1 | One-cycle pulse when the status word is logged |
| ost_evt | output | 32 | Logged event word |
| ost_sts | output | 32 | Logged status word |

## Verification
Every register sits one edge from its cause. Read data, eject_stb and ost_vld are due in the cycle after the strobe. Flag changes from hot-add, hot-remove and control writes show up on irq, and through a status read, one edge after the pulse or write. The bench drives inputs on the falling edge and holds each strobe for exactly one rising edge. It samples results on the next falling edge, so each check falls in the single cycle where the result is due. Pulses are checked again one cycle later to confirm they have dropped.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;

    // dword index inside the window (addr[3:2])
    localparam logic [1:0] DW_SEL = 2'd0;
    localparam logic [1:0] DW_CTL = 2'd1;
    localparam logic [1:0] DW_DAT = 2'd2;

    // command codes carried in byte lane 1 of dword 1
    localparam logic [7:0] CMD_FIND    = 8'd0;
    localparam logic [7:0] CMD_OST_EVT = 8'd1;
    localparam logic [7:0] CMD_OST_STS = 8'd2;

    // control byte bit positions
    localparam int CB_CLR_INS = 1;
    localparam int CB_CLR_REM = 2;
    localparam int CB_EJECT   = 3;

    typedef struct packed {
        logic en;
        logic ins;
        logic rem;
    } slot_t;

    typedef struct packed {
        logic        legacy;
        logic [31:0] sel;
        logic [7:0]  cmd;
        logic [31:0] ost_evt;
        logic [31:0] ost_sts;
        logic        ost_vld;
        logic        ej_stb;
        logic [31:0] rdata;
    } hp_regs_t;

    function automatic logic [31:0] merge_be(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  lanes);
        logic [31:0] r;
        r = old_v;
        for (int b = 0; b < 4; b++) begin
            if (lanes[b]) r[8*b +: 8] = new_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/slot_hp_flags.sv
module slot_hp_flags
    import slot_hp_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_add,
    input  logic [N-1:0] set_rem,
    input  logic [N-1:0] clr_ins,
    input  logic [N-1:0] clr_rem,
    input  logic [N-1:0] clr_en,
    output logic [N-1:0] en_q,
    output logic [N-1:0] ins_q,
    output logic [N-1:0] rem_q
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        slot_t s_d, s_q;

        // clear first, then platform sets win
        always_comb begin
            s_d     = s_q;
            s_d.en  = (s_q.en  & ~clr_en[g])  | set_add[g];
            s_d.ins = (s_q.ins & ~clr_ins[g]) | set_add[g];
            s_d.rem = (s_q.rem & ~clr_rem[g]) | set_rem[g];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign en_q[g]  = s_q.en;
        assign ins_q[g] = s_q.ins;
        assign rem_q[g] = s_q.rem;

        assert_add_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            set_add[g] |=> (s_q.en && s_q.ins));

        assert_eject_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en[g] && !set_add[g] && !set_rem[g]) |=> (!s_q.en && !s_q.rem));
    end

endmodule

// File: rtl/slot_hp_sel.sv
module slot_hp_sel #(
    parameter int N      = 8,
    parameter int SLOT_W = 3
) (
    input  logic [31:0]       sel,
    output logic              in_range,
    output logic [SLOT_W-1:0] idx,
    output logic [N-1:0]      hit
);

    assign in_range = (sel < 32'(N));
    assign idx      = sel[SLOT_W-1:0];

    for (genvar g = 0; g < N; g++) begin : g_hit
        assign hit[g] = (sel == 32'(g));
    end

endmodule

// File: rtl/slot_hp_find.sv
module slot_hp_find #(
    parameter int N      = 8,
    parameter int SLOT_W = 3
) (
    input  logic [N-1:0]      pend,
    output logic              found,
    output logic [SLOT_W-1:0] idx
);

    // scan downward so the lowest pending slot is the last one written
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
    import slot_hp_pkg::*;
#(
    parameter  int NUM_SLOTS = 8,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           addr,
    input  logic [3:0]           be,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [NUM_SLOTS-1:0] hp_add,
    input  logic [NUM_SLOTS-1:0] hp_rem,
    output logic                 irq,
    output logic                 eject_stb,
    output logic [SLOT_W-1:0]    eject_slot,
    output logic                 ost_vld,
    output logic [31:0]          ost_evt,
    output logic [31:0]          ost_sts
);

    localparam int N = NUM_SLOTS;

    hp_regs_t          r_d, r_q;
    logic [SLOT_W-1:0] ej_slot_d, ej_slot_q;

    logic [1:0]        dw;
    logic              modern;
    logic              in_range;
    logic [SLOT_W-1:0] s_idx;
    logic [N-1:0]      hit;
    logic [N-1:0]      en_q, ins_q, rem_q, pend;
    logic              found;
    logic [SLOT_W-1:0] f_idx;
    logic              ctl_ok;
    logic [N-1:0]      clr_ins, clr_rem, clr_en;
    logic              unused_addr;

    assign dw          = addr[3:2];
    assign modern      = ~r_q.legacy;
    assign unused_addr = ^addr[1:0];
    assign pend        = ins_q | rem_q;

    slot_hp_sel #(.N(N), .SLOT_W(SLOT_W)) u_sel (
        .sel      (r_q.sel),
        .in_range (in_range),
        .idx      (s_idx),
        .hit      (hit)
    );

    slot_hp_find #(.N(N), .SLOT_W(SLOT_W)) u_find (
        .pend  (pend),
        .found (found),
        .idx   (f_idx)
    );

    // control byte decode toward the per-slot flags
    always_comb begin
        ctl_ok  = modern && wr && (dw == DW_CTL) && be[0] && in_range;
        clr_ins = hit & {N{ctl_ok & wdata[CB_CLR_INS]}};
        clr_rem = hit & {N{ctl_ok & (wdata[CB_CLR_REM] | wdata[CB_EJECT])}};
        clr_en  = hit & {N{ctl_ok & wdata[CB_EJECT]}};
    end

    slot_hp_flags #(.N(N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_add (hp_add),
        .set_rem (hp_rem),
        .clr_ins (clr_ins),
        .clr_rem (clr_rem),
        .clr_en  (clr_en),
        .en_q    (en_q),
        .ins_q   (ins_q),
        .rem_q   (rem_q)
    );

    always_comb begin
        r_d         = r_q;
        r_d.ost_vld = 1'b0;
        r_d.ej_stb  = 1'b0;
        r_d.rdata   = '0;
        ej_slot_d   = ej_slot_q;

        // one-way switch out of compatibility mode
        if (r_q.legacy && wr && (dw == DW_SEL) && (be == 4'hF) && (wdata == '0)) begin
            r_d.legacy = 1'b0;
        end

        if (modern && wr) begin
            case (dw)
                DW_SEL: r_d.sel = merge_be(r_q.sel, wdata, be);
                DW_CTL: begin
                    if (be[1]) begin
                        r_d.cmd = wdata[15:8];
                        if ((wdata[15:8] == CMD_FIND) && found) begin
                            r_d.sel = 32'(f_idx);
                        end
                    end
                    if (ctl_ok && wdata[CB_EJECT]) begin
                        r_d.ej_stb = 1'b1;
                        ej_slot_d  = s_idx;
                    end
                end
                DW_DAT: begin
                    if (r_q.cmd == CMD_OST_EVT) begin
                        r_d.ost_evt = merge_be(r_q.ost_evt, wdata, be);
                    end else if (r_q.cmd == CMD_OST_STS) begin
                        r_d.ost_sts = merge_be(r_q.ost_sts, wdata, be);
                        r_d.ost_vld = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (rd) begin
            if (r_q.legacy) begin
                if (dw == DW_SEL) r_d.rdata = 32'(en_q);
            end else begin
                case (dw)
                    DW_CTL: r_d.rdata = {29'd0, |(rem_q & hit), |(ins_q & hit), |(en_q & hit)};
                    DW_DAT: r_d.rdata = (r_q.cmd == CMD_FIND) ? r_q.sel : 32'hFFFF_FFFF;
                    default: r_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.legacy <= 1'b1;
            ej_slot_q  <= '0;
        end else begin
            r_q        <= r_d;
            ej_slot_q  <= ej_slot_d;
        end
    end

    assign rdata      = r_q.rdata;
    assign irq        = |pend;
    assign eject_stb  = r_q.ej_stb;
    assign eject_slot = ej_slot_q;
    assign ost_vld    = r_q.ost_vld;
    assign ost_evt    = r_q.ost_evt;
    assign ost_sts    = r_q.ost_sts;

    assert_mode_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.legacy |=> !r_q.legacy);

    assert_oor_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && modern && (dw == DW_CTL) && !in_range) |=> (rdata == '0));

    assert_oor_no_eject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !in_range) |=> !eject_stb);

    assert_find_keeps_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && modern && (dw == DW_CTL) && be[1] && (wdata[15:8] == CMD_FIND) && (pend == '0))
        |=> $stable(r_q.sel));

    assert_ost_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ost_vld |-> $past(wr && (dw == DW_DAT)));

    assert_eject_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eject_stb |-> (32'(eject_slot) < 32'(N)));

endmodule

// File: tb/sim_slot_hp_ctrl.sv
module sim_slot_hp_ctrl;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [3:0]  be = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N-1:0] hp_add = '0;
    logic [N-1:0] hp_rem = '0;
    logic        irq, eject_stb, ost_vld;
    logic [2:0]  eject_slot;
    logic [31:0] ost_evt, ost_sts;

    int n_chk = 0;
    int n_err = 0;

    logic [N-1:0] m_en = '0, m_ins = '0, m_rem = '0;
    logic [31:0]  m_sel = '0;

    always #5 clk = ~clk;

    slot_hp_ctrl #(.NUM_SLOTS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .be(be), .wr(wr), .rd(rd),
        .wdata(wdata), .rdata(rdata), .hp_add(hp_add), .hp_rem(hp_rem),
        .irq(irq), .eject_stb(eject_stb), .eject_slot(eject_slot),
        .ost_vld(ost_vld), .ost_evt(ost_evt), .ost_sts(ost_sts)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic bus_wr(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d);
        addr = a; be = b; wdata = d; wr = 1'b1;
        @(posedge clk); @(negedge clk);
        wr = 1'b0; be = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        @(posedge clk); @(negedge clk);
        d = rdata; rd = 1'b0;
    endtask

    task automatic pulse_hp(input logic [N-1:0] a, input logic [N-1:0] r);
        hp_add = a; hp_rem = r;
        @(posedge clk); @(negedge clk);
        hp_add = '0; hp_rem = '0;
        m_en = m_en | a; m_ins = m_ins | a; m_rem = m_rem | r;
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    function automatic logic [31:0] exp_status();
        if (m_sel >= N) return 32'd0;
        return {29'd0, m_rem[m_sel[2:0]], m_ins[m_sel[2:0]], m_en[m_sel[2:0]]};
    endfunction

    function automatic logic [31:0] exp_find();
        for (int i = 0; i < N; i++) if (m_ins[i] | m_rem[i]) return 32'(i);
        return m_sel;
    endfunction

    // control write with model update; checks eject strobe
    task automatic ctl_wr(input logic [7:0] d);
        logic ej;
        ej = (m_sel < N) && d[3];
        bus_wr(4'h4, 4'b0001, {24'd0, d});
        if (m_sel < N) begin
            if (d[1]) m_ins[m_sel[2:0]] = 1'b0;
            if (d[2] | d[3]) m_rem[m_sel[2:0]] = 1'b0;
            if (d[3]) m_en[m_sel[2:0]] = 1'b0;
        end
        chk("R6 eject_stb", 32'(eject_stb), 32'(ej));
        if (ej) chk("R6 eject_slot", 32'(eject_slot), m_sel);
    endtask

    task automatic find_cmd();
        logic [31:0] v;
        bus_wr(4'h4, 4'b0010, 32'h0000_0000);
        m_sel = exp_find();
        bus_rd(4'h8, v);
        chk("R8 find result", v, m_sel);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", rdata, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 eject_stb", 32'(eject_stb), 0);
        chk("R1 ost_vld", 32'(ost_vld), 0);
        chk("R1 ost_evt", ost_evt, 0);
        chk("R1 ost_sts", ost_sts, 0);
        bus_rd(4'h0, v); chk("R1 legacy bitmap empty", v, 0);

        // R2 / R3 compatibility mode
        pulse_hp(8'h24, 8'h00);
        chk("R2 irq after add", 32'(irq), 1);
        bus_rd(4'h0, v); chk("R3 bitmap", v, 32'h24);
        bus_rd(4'h4, v); chk("R3 other dword zero", v, 0);
        bus_wr(4'h0, 4'hF, 32'h1);
        bus_wr(4'h4, 4'b0001, 32'h0000_0006);
        bus_wr(4'h0, 4'h3, 32'h0);
        bus_rd(4'h0, v); chk("R3 still legacy", v, 32'h24);
        bus_wr(4'h0, 4'hF, 32'h0);
        bus_rd(4'h0, v); chk("R4 dword0 zero in selector mode", v, 0);

        // R8 search, R4 status
        find_cmd();
        chk("R8 lowest slot", m_sel, 2);
        bus_rd(4'h4, v); chk("R4 status slot2", v, 32'h3);

        // R5 clear insert with reserved bits set
        ctl_wr(8'hF2);
        bus_rd(4'h4, v); chk("R5 insert cleared", v, exp_status());
        chk("R5 irq still on", 32'(irq), 1);

        // R5 same-cycle set wins
        bus_wr(4'h0, 4'hF, 32'd5); m_sel = 5;
        pulse_hp(8'h00, 8'h20);
        bus_rd(4'h4, v); chk("R2 remove flag", v, 32'h7);
        hp_add = 8'h20;
        bus_wr(4'h4, 4'b0001, 32'h2);
        hp_add = '0;
        bus_rd(4'h4, v); chk("R5 set wins over clear", v, 32'h7);

        // R6 eject
        ctl_wr(8'h08);
        idle();
        chk("R6 eject_stb one cycle", 32'(eject_stb), 0);
        bus_rd(4'h4, v); chk("R6 after eject", v, 32'h2);

        // R7 out of range
        bus_wr(4'h0, 4'hF, 32'd8); m_sel = 8;
        bus_rd(4'h4, v); chk("R7 oor status", v, 0);
        ctl_wr(8'h0E);
        bus_wr(4'h0, 4'hF, 32'hFFFF_FFFF); m_sel = 32'hFFFF_FFFF;
        bus_rd(4'h4, v); chk("R7 oor status high", v, 0);
        bus_wr(4'h0, 4'hF, 32'd5); m_sel = 5;
        bus_rd(4'h4, v); chk("R7 flags untouched", v, 32'h2);

        // R8 search with nothing pending keeps selector
        ctl_wr(8'h02);
        chk("R2 irq off", 32'(irq), 0);
        find_cmd();
        chk("R8 selector kept", m_sel, 5);

        // R9 / R10 logging commands
        bus_wr(4'h4, 4'b0010, 32'h0000_0100);
        bus_wr(4'h8, 4'hF, 32'h1234_5678);
        bus_rd(4'h8, v); chk("R10 cmd1 read ones", v, 32'hFFFF_FFFF);
        chk("R9 no pulse on cmd1", 32'(ost_vld), 0);
        bus_wr(4'h4, 4'b0010, 32'h0000_0200);
        bus_wr(4'h8, 4'b0001, 32'hFFFF_FFAB);
        chk("R9 ost_vld", 32'(ost_vld), 1);
        chk("R9 ost_evt", ost_evt, 32'h1234_5678);
        chk("R9 ost_sts", ost_sts, 32'h0000_00AB);
        idle();
        chk("R9 ost_vld one cycle", 32'(ost_vld), 0);
        bus_wr(4'h4, 4'b0010, 32'h0000_0900);
        bus_rd(4'h8, v); chk("R10 cmd9 read ones", v, 32'hFFFF_FFFF);
        find_cmd();

        // random mix against the model
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0: begin
                    pulse_hp(N'($urandom & $urandom & $urandom), N'($urandom & $urandom & $urandom));
                    chk("R2 irq level", 32'(irq), 32'(|(m_ins | m_rem)));
                end
                1: begin
                    m_sel = $urandom_range(0, N + 1);
                    bus_wr(4'h0, 4'hF, m_sel);
                end
                2: ctl_wr(8'($urandom_range(0, 255)));
                3: find_cmd();
                4: begin
                    bus_rd(4'h4, v);
                    chk("R4 status random", v, exp_status());
                end
                default: begin
                    bus_rd(4'h0, v);
                    chk("R4 dword0 random", v, 0);
                end
            endcase
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule